// File: doc/BRIEF.md
# Superpage to Page Descriptor Splitter

This block sits between software and a page-granular DMA engine. Software writes superpage descriptors through a simple write-enable port. Each descriptor is a start address and a byte size covering a contiguous region of memory. The block keeps up to 32 accepted descriptors in arrival order. It expands the oldest one into a stream of 8 KB page descriptors on a valid/ready output, one page address per transfer, at consecutive addresses.

When the last page of a superpage is taken by the DMA engine, the block emits a one-cycle completion pulse. The pulse carries the slot number that the superpage was given when it was written, so software can recycle that buffer. In the next cycle the following queued superpage is presented, with no idle cycle between the two. Sizes that are zero or not whole multiples of 32 KB are discarded and latch a sticky error. Writes that find the queue full are also discarded and latch a separate sticky flag. The number of occupied slots is always visible.

Top module: `sp_splitter`

## Requirements
- R1: After reset, pg_valid is 0, slots_used is 0, and both err_bad_size and err_overflow are 0.
- R2: A write (desc_we high for one cycle) whose size is nonzero with its low 15 bits zero (a multiple of 32768 bytes) is queued, and slots_used rises by one on the next cycle.
- R3: A write whose size is zero, or has any of its low 15 bits set, is discarded: slots_used does not change for it, and err_bad_size becomes 1 and stays 1 until reset.
- R4: A write with a legal size that arrives while slots_used is 32 is discarded, even if a superpage completes in the same cycle, and err_overflow becomes 1 and stays 1 until reset.
- R5: For a queued superpage with start address S and size Z, the block offers Z/8192 page addresses in order, the k-th (from 0) equal to (S with its low 13 bits cleared) + 8192*k, modulo 2^ADDR_W. Superpages are served in write order.
- R6: While pg_valid is 1 and pg_ready is 0, pg_valid stays 1 and pg_addr does not change in the next cycle.
- R7: sp_done is high for exactly the cycle in which the last page of a superpage is accepted (pg_valid and pg_ready both 1). sp_done_slot then holds that superpage's slot number. Slots are numbered 0 to 31 in the order legal writes are accepted, wrapping from 31 to 0.
- R8: pg_valid is 1 exactly when slots_used is nonzero. The next superpage's first page is offered in the cycle right after the previous one's last page is accepted.
- R9: A legal write and a completion in the same cycle both take effect: the slot count is unchanged and the new descriptor joins the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Write strobe for one superpage descriptor |
| desc_start | input | ADDR_W | Superpage start address (low 13 bits ignored) |
| desc_size | input | SIZE_W | Superpage size in bytes |
| pg_valid | output | 1 | A page descriptor is offered |
| pg_ready | input | 1 | DMA engine takes the offered page |
| pg_addr | output | ADDR_W | Page start address |
| sp_done | output | 1 | Last page of a superpage accepted this cycle |
| sp_done_slot | output | $clog2(DEPTH) | Slot number of the finished superpage |
| err_bad_size | output | 1 | Sticky: an illegal size was written |
| err_overflow | output | 1 | Sticky: a write was refused because the queue was full |
| slots_used | output | $clog2(DEPTH+1) | Number of occupied slots |

## Verification
Two events can coincide in one cycle: a descriptor write and the acceptance of a superpage's last page. This matters most when the queue is full, because the completion frees a slot but the write must still be refused. The bench keeps the queue full with a write on every cycle while the page consumer accepts every page, so each completion meets a write. It also mixes illegal sizes into that stream. A bench model then judges each cycle on the slot count, the sticky flags and the slot number carried by the completion pulse.

// File: rtl/sp_split_pkg.sv
package sp_split_pkg;

    // Byte offset bits inside one page (8 KB)
    localparam int PAGE_SHIFT = 13;
    // Alignment bits a superpage size must clear (32 KB)
    localparam int SP_SHIFT   = 15;

    typedef enum logic [1:0] {
        SZ_OK        = 2'd0,
        SZ_ZERO      = 2'd1,
        SZ_UNALIGNED = 2'd2
    } size_verdict_e;

endpackage

// File: rtl/sp_size_check.sv
module sp_size_check
    import sp_split_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  logic [SIZE_W-1:0] size,
    output size_verdict_e     verdict
);

    always_comb begin
        if (size == '0)
            verdict = SZ_ZERO;
        else if (size[SP_SHIFT-1:0] != '0)
            verdict = SZ_UNALIGNED;
        else
            verdict = SZ_OK;
    end

endmodule

// File: rtl/sp_slot_queue.sv
module sp_slot_queue #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 26,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [IDX_W-1:0]  head_idx,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              push_ok
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_ptr;
    logic              pop_ok;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign push_ok   = push && !full;
    assign pop_ok    = pop && (count != '0);
    assign head_data = mem[rd_ptr];
    assign head_idx  = rd_ptr;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sp_page_walker.sv
module sp_page_walker
    import sp_split_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PAGES_W = 7,
    localparam int FRAME_W = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               head_valid,
    input  logic [FRAME_W-1:0] head_frame,
    input  logic [PAGES_W-1:0] head_pages,
    input  logic               ready,
    output logic               valid,
    output logic [ADDR_W-1:0]  addr,
    output logic               last_fire
);

    logic [PAGES_W-1:0] page_idx;
    logic [FRAME_W-1:0] cur_frame;
    logic               is_last;
    logic               fire;

    assign valid     = head_valid;
    assign cur_frame = head_frame + FRAME_W'(page_idx);
    assign addr      = {cur_frame, {PAGE_SHIFT{1'b0}}};
    assign is_last   = (page_idx == head_pages - 1'b1);
    assign fire      = valid && ready;
    assign last_fire = fire && is_last;

    always_ff @(posedge clk) begin
        if (rst)
            page_idx <= '0;
        else if (last_fire)
            page_idx <= '0;
        else if (fire)
            page_idx <= page_idx + 1'b1;
    end

endmodule

// File: rtl/sp_splitter.sv
module sp_splitter
    import sp_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20,
    parameter int DEPTH  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       desc_we,
    input  logic [ADDR_W-1:0]          desc_start,
    input  logic [SIZE_W-1:0]          desc_size,
    output logic                       pg_valid,
    input  logic                       pg_ready,
    output logic [ADDR_W-1:0]          pg_addr,
    output logic                       sp_done,
    output logic [$clog2(DEPTH)-1:0]   sp_done_slot,
    output logic                       err_bad_size,
    output logic                       err_overflow,
    output logic [$clog2(DEPTH+1)-1:0] slots_used
);

    localparam int FRAME_W = ADDR_W - PAGE_SHIFT;
    localparam int PAGES_W = SIZE_W - PAGE_SHIFT;
    localparam int ENTRY_W = FRAME_W + PAGES_W;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [PAGES_W-1:0] pages;
    } sp_entry_t;

    size_verdict_e verdict;
    sp_entry_t     new_entry;
    sp_entry_t     head_entry;
    logic          legal_push;
    logic          q_full;
    logic          q_push_ok;
    logic          walk_done;

    sp_size_check #(.SIZE_W(SIZE_W)) size_chk_i (
        .size    (desc_size),
        .verdict (verdict)
    );

    assign legal_push      = desc_we && (verdict == SZ_OK);
    assign new_entry.frame = desc_start[ADDR_W-1:PAGE_SHIFT];
    assign new_entry.pages = desc_size[SIZE_W-1:PAGE_SHIFT];

    sp_slot_queue #(.DEPTH(DEPTH), .DATA_W(ENTRY_W)) queue_i (
        .clk       (clk),
        .rst       (rst),
        .push      (legal_push),
        .push_data (new_entry),
        .pop       (walk_done),
        .head_data (head_entry),
        .head_idx  (sp_done_slot),
        .count     (slots_used),
        .full      (q_full),
        .push_ok   (q_push_ok)
    );

    sp_page_walker #(.ADDR_W(ADDR_W), .PAGES_W(PAGES_W)) walker_i (
        .clk        (clk),
        .rst        (rst),
        .head_valid (slots_used != '0),
        .head_frame (head_entry.frame),
        .head_pages (head_entry.pages),
        .ready      (pg_ready),
        .valid      (pg_valid),
        .addr       (pg_addr),
        .last_fire  (walk_done)
    );

    assign sp_done = walk_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_bad_size <= 1'b0;
            err_overflow <= 1'b0;
        end else begin
            if (desc_we && verdict != SZ_OK)
                err_bad_size <= 1'b1;
            if (legal_push && !q_push_ok)
                err_overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/sp_splitter_chk.sv
module sp_splitter_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20,
    parameter int DEPTH  = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       desc_we,
    input logic [SIZE_W-1:0]          desc_size,
    input logic                       pg_valid,
    input logic                       pg_ready,
    input logic [ADDR_W-1:0]          pg_addr,
    input logic                       sp_done,
    input logic                       err_bad_size,
    input logic                       err_overflow,
    input logic [$clog2(DEPTH+1)-1:0] slots_used
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (pg_valid && !pg_ready) |=> (pg_valid && $stable(pg_addr))); // R6

    AST_NEXT_PAGE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (pg_valid && pg_ready && !sp_done) |=>
            (pg_valid && pg_addr == $past(pg_addr) + ADDR_W'(8192))); // R5

    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        sp_done |-> (pg_valid && pg_ready)); // R7

    AST_VALID_MATCHES_COUNT: assert property (@(posedge clk) disable iff (rst)
        pg_valid == (slots_used != '0)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (desc_we && slots_used == CNT_W'(DEPTH) && !sp_done) |=>
            (slots_used == CNT_W'(DEPTH))); // R4

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        slots_used <= CNT_W'(DEPTH)); // R9

    AST_SIZE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_bad_size |=> err_bad_size); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_overflow |=> err_overflow); // R4

    AST_BAD_SIZE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (desc_we && desc_size == '0) |=> err_bad_size); // R3

endmodule

bind sp_splitter sp_splitter_chk #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .desc_we      (desc_we),
    .desc_size    (desc_size),
    .pg_valid     (pg_valid),
    .pg_ready     (pg_ready),
    .pg_addr      (pg_addr),
    .sp_done      (sp_done),
    .err_bad_size (err_bad_size),
    .err_overflow (err_overflow),
    .slots_used   (slots_used)
);

// File: tb/sp_splitter_tb.sv
module sp_splitter_tb_top;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 20;
    localparam int DEPTH  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              desc_we = 1'b0;
    logic [ADDR_W-1:0] desc_start = '0;
    logic [SIZE_W-1:0] desc_size = '0;
    logic              pg_ready = 1'b0;
    logic              pg_valid;
    logic [ADDR_W-1:0] pg_addr;
    logic              sp_done;
    logic [4:0]        sp_done_slot;
    logic              err_bad_size;
    logic              err_overflow;
    logic [5:0]        slots_used;

    sp_splitter #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .desc_we      (desc_we),
        .desc_start   (desc_start),
        .desc_size    (desc_size),
        .pg_valid     (pg_valid),
        .pg_ready     (pg_ready),
        .pg_addr      (pg_addr),
        .sp_done      (sp_done),
        .sp_done_slot (sp_done_slot),
        .err_bad_size (err_bad_size),
        .err_overflow (err_overflow),
        .slots_used   (slots_used)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // bench model of the queue
    logic [31:0] m_addr  [DEPTH];
    int          m_pages [DEPTH];
    int          m_slot  [DEPTH];
    int          m_head = 0;
    int          m_count = 0;
    int          m_pidx = 0;
    int          m_next_slot = 0;
    bit          m_err_size = 0;
    bit          m_err_ovf = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [15:0] lf = 16'hACE1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit size_legal(input int sz);
        return (sz != 0) && ((sz % 32768) == 0);
    endfunction

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // one cycle: drive at negedge, check, update model, advance to next negedge
    task automatic step(input bit we, input logic [31:0] st, input int sz, input bit rdy);
        bit          exp_valid;
        bit          exp_done;
        logic [31:0] exp_addr;
        bit          popped;
        desc_we    = we;
        desc_start = st;
        desc_size  = SIZE_W'(sz);
        pg_ready   = rdy;
        #1;
        exp_valid = (m_count > 0);
        check(slots_used == 6'(m_count), "R9 slots_used", slots_used, m_count);
        check(pg_valid == exp_valid, "R8 pg_valid", pg_valid, exp_valid);
        check(err_bad_size == m_err_size, "R3 err_bad_size", err_bad_size, m_err_size);
        check(err_overflow == m_err_ovf, "R4 err_overflow", err_overflow, m_err_ovf);
        if (prev_stall)
            check(pg_valid && pg_addr == prev_addr, "R6 hold", pg_addr, prev_addr);
        exp_done = 0;
        if (exp_valid) begin
            exp_addr = m_addr[m_head] + 32'(m_pidx) * 32'd8192;
            check(pg_addr == exp_addr, "R5 pg_addr", pg_addr, exp_addr);
            exp_done = rdy && (m_pidx == m_pages[m_head] - 1);
        end
        check(sp_done == exp_done, "R7 sp_done", sp_done, exp_done);
        if (exp_done)
            check(sp_done_slot == 5'(m_slot[m_head]), "R7 sp_done_slot",
                  sp_done_slot, m_slot[m_head]);
        prev_stall = exp_valid && !rdy;
        prev_addr  = pg_addr;
        // model update
        popped = 0;
        if (exp_valid && rdy) begin
            if (exp_done) begin
                popped = 1;
                m_pidx = 0;
            end else begin
                m_pidx++;
            end
        end
        if (we) begin
            if (!size_legal(sz)) begin
                m_err_size = 1;
            end else if (m_count == DEPTH) begin
                m_err_ovf = 1;   // R4: refused even when a pop coincides
            end else begin
                int tail;
                tail = (m_head + m_count) % DEPTH;
                m_addr[tail]  = st & 32'hFFFF_E000;
                m_pages[tail] = sz / 8192;
                m_slot[tail]  = m_next_slot;
                m_next_slot   = (m_next_slot + 1) % DEPTH;
                m_count++;
            end
        end
        if (popped) begin
            m_head = (m_head + 1) % DEPTH;
            m_count--;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain(input bit random_ready);
        int guard = 0;
        while (m_count > 0 && guard < 5000) begin
            lf_step();
            step(0, '0, 0, random_ready ? (lf[0] | lf[1]) : 1'b1);
            guard++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        check(!pg_valid, "R1 pg_valid after reset", pg_valid, 0);
        check(slots_used == 0, "R1 slots_used after reset", slots_used, 0);
        check(!err_bad_size && !err_overflow, "R1 flags after reset",
              {err_bad_size, err_overflow}, 0);
        step(0, '0, 0, 0);

        // R2/R3: sweep sizes in 4 KB steps, consumer stalled
        for (int k = 0; k <= 24; k++)
            step(1, 32'h1000_0000 + 32'(k) * 32'h0010_0000, k * 4096, 0);
        step(1, 32'h3000_0000, 32'h8001, 0);
        step(1, 32'h3100_0000, 32'hF8000, 0);
        check(m_count == 4, "R2 legal descriptors accepted", m_count, 4);
        drain(1);

        // R5: misaligned start and address wrap
        step(1, 32'hABCD_1FFF, 65536, 1);
        step(1, 32'hFFFF_C000, 32768, 1);
        drain(1);

        // R4: fill past 32 with the consumer stalled
        for (int i = 0; i < DEPTH + 3; i++)
            step(1, 32'h2000_0000 + 32'(i) * 32'h0004_0000, 32768, 0);
        check(slots_used == 6'(DEPTH), "R4 full count", slots_used, DEPTH);
        check(err_overflow, "R4 overflow flag", err_overflow, 1);

        // R9/R4: write every cycle while pages drain, mixed sizes
        for (int i = 0; i < 400; i++) begin
            lf_step();
            step(1, {lf, 16'h0000}, lf[2] ? 65536 : (lf[3] ? 32768 : 12288), 1'b1);
        end
        drain(1);
        // R9: write and completion together below full
        step(1, 32'h4000_0000, 32768, 1);
        for (int i = 0; i < 3; i++) step(0, '0, 0, 1);
        step(1, 32'h5000_0000, 32768, 1);
        drain(0);
        step(0, '0, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule